// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block watches a processor's health and drives its active-low reset output. It combines four inputs: a supply-good flag, a manual reset request, an inhibit input and a periodic kick from software. All timing is counted in clock cycles. A single timeout length `TWD` sets the watchdog period. The reset hold length is derived as `TWD/9` and the blind window as `TWD/10`. The power-on delay `TPLH`, the supply-loss delay `TPHL` and the manual-reset delay `TMR` are separate parameters. `TWD` must be at least 90.

The watchdog alternates between two phases. A hold phase lasts `TWD/9` cycles. It is followed by a timeout phase of `TWD` cycles. An accepted kick during the timeout phase sends the watchdog back to a hold phase with the output high. If the timeout phase expires with no accepted kick, the next hold phase is spent with the output low. Kicks are not accepted during a hold phase. They are also not accepted during the first `TWD/10` cycles of a timeout phase, so a kick that comes too early counts as a missed one.

The supply-good flag, the manual reset and the inhibit input are synchronous to `clk`. The kick input `sck` may be asynchronous. The watchdog is held at the start of a hold phase while the supply is bad, while a manual reset is active, and while inhibit is asserted.

Top module: `wdt_reset_sup`

## Requirements
- R1: After `rst`, `resetb` is low. It goes high only once `vdd_ok` has been high for `TPLH` consecutive cycles.
- R2: A kick is a rising edge of `sck` seen through a two-flop synchronizer. An accepted kick during the timeout phase starts a hold phase with `resetb` high. A fresh full timeout phase follows it.
- R3: Every hold phase lasts exactly `TWD/9` cycles, after which a timeout phase starts.
- R4: When a timeout phase runs `TWD` cycles with no accepted kick, `resetb` is low for the whole following hold phase.
- R5: `resetb` goes low once `vdd_ok` has been low for `TPHL` consecutive cycles. A shorter dip has no effect on `resetb`.
- R6: While `inh_n` is low, `resetb` is high unless the supply is bad or a manual reset is active. The watchdog neither times out nor accepts kicks during this time.
- R7: After `inh_n` rises, the watchdog runs a full hold phase with `resetb` high and then a full timeout phase.
- R8: `resetb` goes low once `mr_n` has been low for `TMR` consecutive cycles, regardless of `sck` and `inh_n`.
- R9: After `mr_n` returns high, `resetb` goes high after `TPLH` cycles, and the watchdog restarts with a hold phase followed by a timeout phase.
- R10: Priority, highest first: supply bad, then manual reset, then inhibit, then the watchdog.
- R11: A kick is ignored during a hold phase, and during the first `TWD/10` cycles of a timeout phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vdd_ok | input | 1 | Supply-good flag, synchronous |
| sck | input | 1 | Watchdog kick; a rising edge is a kick; may be asynchronous |
| inh_n | input | 1 | Inhibit, active low; forces the output high |
| mr_n | input | 1 | Manual reset request, active low |
| resetb | output | 1 | Reset output, active low |

## Verification
The kick tests sit on both sides of the blind-window edge. Kicks are placed so that the first is evaluated one cycle before the window ends and the next exactly at its end. A design with an off-by-one window would therefore time out early, or would accept the early kick and time out late. A second kick placed inside a hold phase moves the expected timeout if it is wrongly accepted. Other cases catch a wrong priority: supply loss during inhibit, and manual reset during inhibit. A supply dip one cycle shorter than `TPHL`, and the exact cycle counts of each delay, expose counters that do not restart on a glitch or that end one cycle off.

// File: rtl/wdt_reset_sup.sv
module wdt_reset_sup #(
  parameter int TWD  = 90,
  parameter int TPLH = 8,
  parameter int TPHL = 4,
  parameter int TMR  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_ok,
  input  logic sck,
  input  logic inh_n,
  input  logic mr_n,
  output logic resetb
);

  localparam int TWR  = TWD / 9;
  localparam int TWDI = TWD / 10;
  localparam int WW   = $clog2(TWD + 1);
  localparam int SMAX = (TPLH > TPHL) ? TPLH : TPHL;
  localparam int MMAX = (TPLH > TMR) ? TPLH : TMR;
  localparam int SW   = $clog2(SMAX + 1);
  localparam int MW   = $clog2(MMAX + 1);

  localparam logic [WW-1:0] WD_LAST = WW'(TWD - 1);
  localparam logic [WW-1:0] WR_LAST = WW'(TWR - 1);
  localparam logic [WW-1:0] WDI_LEN = WW'(TWDI);
  localparam logic [SW-1:0] UP_LAST = SW'(TPLH - 1);
  localparam logic [SW-1:0] DN_LAST = SW'(TPHL - 1);
  localparam logic [MW-1:0] MR_LAST = MW'(TMR - 1);
  localparam logic [MW-1:0] RL_LAST = MW'(TPLH - 1);

  logic [2:0]    sync;
  logic          kick;
  logic          pg;
  logic [SW-1:0] scnt;
  logic          mr_act;
  logic [MW-1:0] mcnt;
  logic          charge, bark, hold;
  logic [WW-1:0] wcnt;

  assign kick = sync[1] & ~sync[2];
  assign hold = ~pg | mr_act | ~inh_n;
  assign resetb = pg & ~mr_act & (~inh_n | ~bark);

  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[1:0], sck};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg   <= 1'b0;
      scnt <= '0;
    end else if (vdd_ok != pg) begin
      if (scnt == (pg ? DN_LAST : UP_LAST)) begin
        pg   <= ~pg;
        scnt <= '0;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end else begin
      scnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_act <= 1'b0;
      mcnt   <= '0;
    end else if (mr_n == mr_act) begin
      if (mcnt == (mr_act ? RL_LAST : MR_LAST)) begin
        mr_act <= ~mr_act;
        mcnt   <= '0;
      end else begin
        mcnt <= mcnt + 1'b1;
      end
    end else begin
      mcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      charge <= 1'b1;
      bark   <= 1'b0;
      wcnt   <= '0;
    end else if (charge) begin
      if (wcnt == WR_LAST) begin
        charge <= 1'b0;
        bark   <= 1'b0;
        wcnt   <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (kick && wcnt >= WDI_LEN) begin
      charge <= 1'b1;
      bark   <= 1'b0;
      wcnt   <= '0;
    end else if (wcnt == WD_LAST) begin
      charge <= 1'b1;
      bark   <= 1'b1;
      wcnt   <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end

  a_r1_rise_needs_supply: assert property (@(posedge clk) disable iff (rst)
    $rose(pg) |-> $past(vdd_ok));

  a_r5_dip_filtered: assert property (@(posedge clk) disable iff (rst)
    (pg && vdd_ok) |=> pg);

  a_r8_mr_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(mr_act) |-> !$past(mr_n));

  a_r3_hold_runs: assert property (@(posedge clk) disable iff (rst)
    (charge && !hold && wcnt != WR_LAST) |=> charge);

  a_r4_timeout_bark: assert property (@(posedge clk) disable iff (rst)
    (!charge && !hold && !kick && wcnt == WD_LAST) |=> (charge && bark));

  a_r11_blind_window: assert property (@(posedge clk) disable iff (rst)
    (!charge && !hold && wcnt < WDI_LEN) |=> !charge);

  a_r6_inhibit_holds: assert property (@(posedge clk) disable iff (rst)
    !inh_n |=> (charge && !bark && wcnt == '0));

  a_r10_supply_first: assert property (@(posedge clk) disable iff (rst)
    !pg |-> !resetb);

endmodule

// File: tb/test_wdt_reset_sup.sv
`timescale 1ns/1ps
module test_wdt_reset_sup;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vdd_ok = 1'b0, sck = 1'b0, inh_n = 1'b1, mr_n = 1'b1;
  logic resetb;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wdt_reset_sup #(.TWD(90), .TPLH(8), .TPHL(4), .TMR(3)) i_wdt_reset_sup (
    .clk(clk), .rst(rst), .vdd_ok(vdd_ok), .sck(sck),
    .inh_n(inh_n), .mr_n(mr_n), .resetb(resetb)
  );

  // {req[3:0], vdd_ok, mr_n, inh_n, expected resetb, cycles[15:0]}
  localparam logic [23:0] VEC [27] = '{
    {4'd1,  4'b1110, 16'd7},   // R1 power-on delay not yet over
    {4'd1,  4'b1111, 16'd1},   // R1 high after TPLH
    {4'd4,  4'b1111, 16'd99},  // R4 one cycle before expiry
    {4'd4,  4'b1110, 16'd1},   // R4 expiry drives low
    {4'd3,  4'b1110, 16'd9},   // R3 hold still running
    {4'd3,  4'b1111, 16'd1},   // R3 hold ends after TWD/9
    {4'd6,  4'b1101, 16'd200}, // R6 inhibit keeps output high
    {4'd5,  4'b0101, 16'd3},   // R5 supply loss not yet seen
    {4'd10, 4'b0100, 16'd1},   // R10 supply loss beats inhibit
    {4'd1,  4'b1100, 16'd7},   // R1 supply back, delay running
    {4'd1,  4'b1101, 16'd1},   // R1 supply good again
    {4'd7,  4'b1111, 16'd99},  // R7 restart after inhibit
    {4'd7,  4'b1110, 16'd1},   // R7 full hold plus timeout
    {4'd3,  4'b1111, 16'd10},  // R3 hold after timeout
    {4'd8,  4'b1011, 16'd2},   // R8 manual reset not yet
    {4'd8,  4'b1010, 16'd1},   // R8 low after TMR
    {4'd8,  4'b1010, 16'd50},  // R8 stays low
    {4'd9,  4'b1110, 16'd7},   // R9 release delay running
    {4'd9,  4'b1111, 16'd1},   // R9 high after TPLH
    {4'd9,  4'b1111, 16'd99},  // R9 watchdog restarted
    {4'd9,  4'b1110, 16'd1},   // R9 restarted watchdog expires
    {4'd3,  4'b1111, 16'd10},  // R3 hold ends
    {4'd10, 4'b1000, 16'd3},   // R10 manual reset beats inhibit
    {4'd9,  4'b1111, 16'd8},   // R9 release
    {4'd5,  4'b0111, 16'd3},   // R5 short dip
    {4'd5,  4'b1111, 16'd1},   // R5 short dip ignored
    {4'd5,  4'b0110, 16'd4}    // R5 loss after TPHL
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (resetb !== exp) begin
      fails++;
      $display("FAIL %s: resetb=%b expected %b at %0t", req, resetb, exp, $time);
    end
  endtask

  task automatic start_timeout();
    rst = 1'b1; vdd_ok = 1'b0; mr_n = 1'b1; inh_n = 1'b1; sck = 1'b0;
    cyc(2);
    rst = 1'b0;
    vdd_ok = 1'b1;
    cyc(18);
    check(1'b1, "R2 timeout phase start");
  endtask

  task automatic kick_after(input int d);
    cyc(d);
    sck = 1'b1;
    cyc(2);
    sck = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, resetb=%b expected completion", resetb);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check(1'b0, "R1 reset state");

    for (int i = 0; i < 27; i++) begin
      vdd_ok = VEC[i][19];
      mr_n   = VEC[i][18];
      inh_n  = VEC[i][17];
      cyc(int'(VEC[i][15:0]));
      check(VEC[i][16], $sformatf("R%0d vector %0d", VEC[i][23:20], i));
    end

    // R2 kick accepted mid-timeout: expiry moves from 90 to 123
    start_timeout();
    kick_after(20);
    cyc(100);
    check(1'b1, "R2 kicked watchdog still high");
    cyc(1);
    check(1'b0, "R2 expiry after kick");

    // R11 kick evaluated one cycle before window end is ignored
    start_timeout();
    kick_after(6);
    cyc(81);
    check(1'b1, "R11 before expiry");
    cyc(1);
    check(1'b0, "R11 early kick ignored");

    // R11 kick evaluated exactly at window end is accepted
    start_timeout();
    kick_after(7);
    cyc(100);
    check(1'b1, "R11 boundary kick accepted");
    cyc(1);
    check(1'b0, "R11 boundary kick expiry");

    // R11 kick during hold phase is ignored
    start_timeout();
    kick_after(30);
    kick_after(3);
    cyc(95);
    check(1'b1, "R11 hold-phase kick");
    cyc(1);
    check(1'b0, "R11 hold-phase kick ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule